// File: doc/BRIEF.md
# Shared-Memory Collision Busy Arbiter

This block sits beside a two-port shared memory and decides which port may proceed when both ports address the same word at once. Each side presents an enable, a write strobe and a word address. A collision exists only while both enables are high and the two addresses are equal; the arbiter then lets one side through and raises busy toward the other, whose write is suppressed before it reaches the storage array.

A mode pin selects where busy comes from. As the lead device, the block computes busy itself from its own collision logic. As a follower, used when several memories are placed side by side to build a wider word, the busy levels arrive from the lead device and are taken as given, so every slice blocks the same port. Winner choice on a fresh collision favours the port that was enabled first, with the left side taking a same-cycle tie, and a side that holds the grant keeps it for as long as the collision lasts.

Top module: `dpbusy_arb`

## Requirements
- R1: With lead mode selected, both busy outputs are 0 whenever either enable is low or the two addresses differ in any bit.
- R2: With lead mode selected, when a collision begins and both ports were enabled (or both disabled) in the previous cycle, the left side wins: right busy is 1 and left busy is 0 in that same cycle.
- R3: With lead mode selected, when a collision begins and only the right port was enabled in the previous cycle, the right side wins: left busy is 1 and right busy is 0.
- R4: A side that won a collision keeps winning in every following cycle while the collision continues; the other side cannot take it over.
- R5: Busy falls in the same cycle in which the addresses stop matching or either enable is dropped, and a later new collision is decided afresh.
- R6: Busy is never 1 on both sides at once in lead mode, and at most one side's grant is held.
- R7: With follower mode selected (mode pin 0), each busy output equals the corresponding busy input, and colliding addresses alone raise no busy.
- R8: A side's write-permit output is 1 exactly when its enable and write strobe are both 1 and its busy output is 0.
- R9: After reset no grant is held and the previous-cycle enable record is cleared, so the first collision goes to the left side.
- R10: The address is ADDR_W bits wide (default 14, 16K words); a difference in the top bit alone means no collision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_mode | input | 1 | 1 = compute busy locally, 0 = take busy from inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_in | input | 1 | Left busy from lead device (follower mode) |
| r_busy_in | input | 1 | Right busy from lead device (follower mode) |
| l_busy | output | 1 | Left port is blocked |
| r_busy | output | 1 | Right port is blocked |
| l_wr_ok | output | 1 | Left write may reach the array |
| r_wr_ok | output | 1 | Right write may reach the array |

## Verification
Collision detection is probed with equal addresses under one enable, with addresses differing only in the top bit, and with a true match, which separates the enable gate from the comparator width. Fresh collisions are started by same-cycle arrival and by right-first arrival, telling the tie rule apart from the first-come rule, and long collisions show that the winner does not flip. Release is driven both by an address change and by dropping an enable, and follower mode is run with colliding addresses and every busy-input pattern to show that only the inputs matter and that writes are gated by them.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;
endpackage

// File: rtl/dpbusy_cmp.sv
module dpbusy_cmp #(
   parameter int ADDR_W = 14
) (
   input  logic              a_en,
   input  logic              b_en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              hit
);
   logic [ADDR_W-1:0] diff;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("dpbusy_cmp: ADDR_W must be at least 1");
      end
   endgenerate

   always_comb begin
      diff = a_addr ^ b_addr;
      hit  = a_en && b_en && (diff == '0);
   end
endmodule

// File: rtl/dpbusy_grant.sv
module dpbusy_grant
   import dpbusy_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic hit,
   input  logic l_en,
   input  logic r_en,
   output logic win_l,
   output logic win_r
);
   logic   hold_l, hold_r;
   logic   seen_l, seen_r;
   owner_e owner;

   always_comb begin
      owner = OWN_NONE;
      if (active && hit) begin
         if (hold_l)                 owner = OWN_LEFT;
         else if (hold_r)            owner = OWN_RIGHT;
         else if (seen_r && !seen_l) owner = OWN_RIGHT;
         else                        owner = OWN_LEFT;
      end
      win_l = (owner == OWN_LEFT);
      win_r = (owner == OWN_RIGHT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l <= 1'b0;
         hold_r <= 1'b0;
         seen_l <= 1'b0;
         seen_r <= 1'b0;
      end else begin
         hold_l <= win_l;
         hold_r <= win_r;
         seen_l <= l_en;
         seen_r <= r_en;
      end
   end

   assert_grant_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_l && hold_r));

   assert_keep_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_l && active && hit) |-> win_l);

   assert_keep_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_r && active && hit) |-> win_r);
endmodule

// File: rtl/dpbusy_arb.sv
module dpbusy_arb #(
   parameter int ADDR_W        = 14,
   parameter bit FOLLOWER_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lead_mode,
   input  logic              l_en,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_in,
   input  logic              r_busy_in,
   output logic              l_busy,
   output logic              r_busy,
   output logic              l_wr_ok,
   output logic              r_wr_ok
);
   localparam int WORDS = 1 << ADDR_W;

   logic is_lead;
   logic hit;
   logic win_l, win_r;

   generate
      if (WORDS < 2) begin : g_bad_depth
         $error("dpbusy_arb: address space too small");
      end
      if (FOLLOWER_CAPABLE) begin : g_mode_pin
         assign is_lead = lead_mode;
      end else begin : g_lead_only
         assign is_lead = 1'b1;
      end
   endgenerate

   dpbusy_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .a_en   (l_en),
      .b_en   (r_en),
      .a_addr (l_addr),
      .b_addr (r_addr),
      .hit    (hit)
   );

   dpbusy_grant u_grant (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (is_lead),
      .hit    (hit),
      .l_en   (l_en),
      .r_en   (r_en),
      .win_l  (win_l),
      .win_r  (win_r)
   );

   always_comb begin
      if (is_lead) begin
         l_busy = win_r;
         r_busy = win_l;
      end else begin
         l_busy = l_busy_in;
         r_busy = r_busy_in;
      end
      l_wr_ok = l_en && l_we && !l_busy;
      r_wr_ok = r_en && r_we && !r_busy;
   end

   assert_quiet_no_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && (!l_en || !r_en || (l_addr != r_addr))) |-> (!l_busy && !r_busy));

   assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_lead |-> !(l_busy && r_busy));

   assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !is_lead |-> ((l_busy == l_busy_in) && (r_busy == r_busy_in)));

   assert_wr_block_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy |-> !l_wr_ok);

   assert_wr_block_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
      r_busy |-> !r_wr_ok);

   assert_no_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lead && r_busy && hit) |=> ((is_lead && hit) |-> r_busy));
endmodule

// File: tb/dpbusy_arb_bench.sv
module dpbusy_arb_bench;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lead_mode = 1'b1;
   logic          l_en = 0, l_we = 0, r_en = 0, r_we = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_in = 0, r_busy_in = 0;
   logic          l_busy, r_busy, l_wr_ok, r_wr_ok;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dpbusy_arb #(.ADDR_W(AW)) u_dpbusy_arb (
      .clk(clk), .rst_n(rst_n), .lead_mode(lead_mode),
      .l_en(l_en), .l_we(l_we), .l_addr(l_addr),
      .r_en(r_en), .r_we(r_we), .r_addr(r_addr),
      .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
      .l_busy(l_busy), .r_busy(r_busy),
      .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
   );

   // packed observation: {l_busy, r_busy, l_wr_ok, r_wr_ok}
   task automatic check(input string req, input string what, input logic [3:0] exp);
      logic [3:0] act;
      act = {l_busy, r_busy, l_wr_ok, r_wr_ok};
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // drive just after a falling edge, settle, then observe
   task automatic drive(input logic le, input logic lw, input logic [AW-1:0] la,
                        input logic re, input logic rw, input logic [AW-1:0] ra);
      @(negedge clk);
      l_en = le; l_we = lw; l_addr = la;
      r_en = re; r_we = rw; r_addr = ra;
      #1;
   endtask

   task automatic idle();
      drive(0, 0, '0, 0, 0, '0);
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9", "outputs during reset", 4'b0000);
      rst_n = 1;
      // first collision after reset: both enables arrive together -> left
      drive(1, 1, 14'h0123, 1, 1, 14'h0123);
      check("R9", "first collision after reset", 4'b0110);
      idle();
   endtask

   task automatic t_no_collide();
      drive(1, 1, 14'h2AAA, 0, 1, 14'h2AAA);
      check("R1", "right enable low", 4'b0010);
      drive(0, 1, 14'h0555, 1, 1, 14'h0555);
      check("R1", "left enable low", 4'b0001);
      drive(1, 1, 14'h3FFF, 1, 1, 14'h1FFF);
      check("R10", "top address bit differs", 4'b0011);
      drive(1, 0, 14'h0000, 1, 0, 14'h0001);
      check("R1", "low address bit differs, reads", 4'b0000);
      idle();
   endtask

   task automatic t_tie();
      drive(1, 1, 14'h3FFF, 1, 1, 14'h3FFF);
      check("R2", "same-cycle arrival left wins", 4'b0110);
      drive(1, 1, 14'h3FFF, 1, 1, 14'h3FFF);
      check("R4", "left keeps grant", 4'b0110);
      // both enabled before at different addresses, then match -> tie rule
      drive(1, 1, 14'h0010, 1, 1, 14'h0020);
      check("R5", "address change releases", 4'b0011);
      drive(1, 1, 14'h0020, 1, 1, 14'h0020);
      check("R2", "both enabled earlier, left wins", 4'b0110);
      idle();
   endtask

   task automatic t_right_first();
      drive(0, 0, 14'h0000, 1, 1, 14'h1234);
      check("R8", "right alone writes", 4'b0001);
      drive(1, 1, 14'h1234, 1, 1, 14'h1234);
      check("R3", "right arrived first wins", 4'b1001);
      for (int i = 0; i < 4; i++) begin
         drive(1, 1, 14'h1234, 1, 1, 14'h1234);
         check("R4", "right keeps grant", 4'b1001);
      end
      drive(1, 1, 14'h1234, 0, 1, 14'h1234);
      check("R5", "right enable drop releases", 4'b0010);
      // left now was enabled first; right returns -> left wins
      drive(1, 1, 14'h1234, 1, 1, 14'h1234);
      check("R5", "new collision decided afresh", 4'b0110);
      idle();
   endtask

   task automatic t_read_collide();
      drive(0, 0, 14'h0000, 1, 0, 14'h0777);
      drive(1, 0, 14'h0777, 1, 0, 14'h0777);
      check("R3", "read collision right first", 4'b1000);
      idle();
   endtask

   task automatic t_follower();
      lead_mode = 0;
      l_busy_in = 0; r_busy_in = 0;
      drive(1, 1, 14'h0ABC, 1, 1, 14'h0ABC);
      check("R7", "colliding with no busy in", 4'b0011);
      l_busy_in = 1; r_busy_in = 0;
      drive(1, 1, 14'h0ABC, 1, 1, 14'h0ABC);
      check("R7", "left busy in", 4'b1001);
      l_busy_in = 0; r_busy_in = 1;
      drive(1, 1, 14'h0001, 1, 1, 14'h0002);
      check("R7", "right busy in, no match", 4'b0110);
      l_busy_in = 1; r_busy_in = 1;
      drive(1, 1, 14'h0001, 1, 0, 14'h0002);
      check("R8", "both busy in, writes blocked", 4'b1100);
      l_busy_in = 0; r_busy_in = 0;
      lead_mode = 1;
      idle();
      check("R1", "back to lead, idle", 4'b0000);
   endtask

   initial begin
      t_reset();
      t_no_collide();
      t_tie();
      t_right_first();
      t_read_collide();
      t_follower();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule